// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block buffers received characters for a serial port and keeps, beside each stored byte, a three-bit tag. The tag records whether that character arrived with a framing fault, a parity fault or a line break. The receiver writes each byte and its tag in one cycle. Software then reads the oldest character through two strobes: one for the data holding register and one for the error status register.

An error is not reported when the faulty character arrives. It is reported only when that character becomes the oldest unread one. The interrupt request then stays up until software has read both the data and the status of that character. A clean character is released by a data read alone.

A separate sticky overrun flag records any character that arrived while every slot was occupied. That character is dropped, and the stored characters are left as they were.

Head sequencing is a small state machine with three states:
- `HS_WAIT`: nothing has been read yet for the current head.
- `HS_DATA_SEEN`: the data has been read, and the status is still pending.
- `HS_STAT_SEEN`: the status has been read, and the data is still pending.

Its transitions, for an errored head, are:
- WAIT to DATA_SEEN on a data read alone.
- WAIT to STAT_SEEN on a status read alone.
- WAIT with both strobes together releases the head and stays in WAIT.
- DATA_SEEN to WAIT on a status read, which releases the head.
- STAT_SEEN to WAIT on a data read, which releases the head.

For a clean head, or an empty FIFO, the machine stays in WAIT, and a data read releases a clean head.

Top module: `rxerr_fifo`

## Requirements
- R1: Each accepted write stores the byte and its tag in arrival order. The tag is bit 0 framing fault, bit 1 parity fault, bit 2 break. `head_data`/`head_stat` show the oldest entry one cycle after it is written.
- R2: `err_irq` is high exactly when the FIFO is non-empty and the head tag is non-zero. Writing an errored character behind a clean head leaves it low.
- R3: When the head tag is zero, a `rd_data_stb` alone removes the head on that clock edge. A `rd_stat_stb` on a clean head removes nothing.
- R4: When the head tag is non-zero, the head is removed only once both strobes have been seen, in either order or in the same cycle. One strobe alone leaves the head, and `err_irq`, in place.
- R5: A write while 16 entries are held, with no removal in that cycle, is dropped. The count and head stay unchanged and `overrun` goes high.
- R6: `overrun` stays high until a cycle with `rd_stat_stb` and no new drop. A drop in the same cycle as a status read leaves it high.
- R7: A write to a full FIFO in the same cycle as a removal is accepted. The count stays 16, and the written byte appears as the last entry.
- R8: Read strobes on an empty FIFO have no effect. A write with a read strobe on an empty FIFO yields count 1 with the written entry at the head.
- R9: After reset, count, `overrun` and `err_irq` are 0, and `head_data`/`head_stat` read 0 while empty.
- R10: `count` reports occupancy between 0 and 16 after every edge.
- R11: For characters A..E with a framing fault on B and a parity fault on D, `err_irq` is high only while B or D is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received byte |
| wr_frame | input | 1 | Framing fault for this byte |
| wr_parity | input | 1 | Parity fault for this byte |
| wr_break | input | 1 | Break detected for this byte |
| rd_data_stb | input | 1 | Data holding register read |
| rd_stat_stb | input | 1 | Error status register read |
| head_data | output | 8 | Oldest stored byte, 0 when empty |
| head_stat | output | 3 | Oldest stored tag {break, parity, frame}, 0 when empty |
| count | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky drop flag |
| err_irq | output | 1 | Errored entry at the head |

## Verification
The assertions assume the strobes are single-cycle pulses, synchronous to `clk`, and that `rd_data_stb`/`rd_stat_stb` may arrive at any time, including on an empty FIFO. Their state-based properties hold only under that assumption. The stimulus drives each strobe for exactly one clock and returns every input to zero between operations. Every overlap the requirements name (write with read on full or empty, both reads together, drop together with status read) is produced as a deliberate single-cycle combination, never by timing accident.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rx_tag_t;

    typedef enum logic [1:0] {
        HS_WAIT      = 2'd0,
        HS_DATA_SEEN = 2'd1,
        HS_STAT_SEEN = 2'd2
    } head_state_t;

endpackage

// File: rtl/rxerr_store.sv
module rxerr_store
    import rxerr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  rx_tag_t       push_tag,
    input  logic          pop,
    output logic [DW-1:0] hd_data,
    output rx_tag_t       hd_tag,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] dmem [DEPTH];
    rx_tag_t       tmem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign full  = (occ == FULL_CNT);
    assign empty = (occ == '0);

    always_ff @(posedge clk) begin
        if (push) begin
            dmem[wptr] <= push_data;
            tmem[wptr] <= push_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            if (push && !pop)      occ <= occ + 1'b1;
            else if (pop && !push) occ <= occ - 1'b1;
        end
    end

    always_comb begin
        hd_data = '0;
        hd_tag  = '0;
        if (!empty) begin
            hd_data = dmem[rptr];
            hd_tag  = tmem[rptr];
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_CNT);  // R10

endmodule

// File: rtl/rxerr_head_fsm.sv
module rxerr_head_fsm
    import rxerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic head_err,
    input  logic rd_data_stb,
    input  logic rd_stat_stb,
    output logic pop
);

    head_state_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HS_WAIT;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        pop = 1'b0;
        if (!nonempty) begin
            nxt = HS_WAIT;
        end else if (!head_err) begin
            pop = rd_data_stb;
            nxt = HS_WAIT;
        end else begin
            unique case (st)
                HS_WAIT: begin
                    if (rd_data_stb && rd_stat_stb) pop = 1'b1;
                    else if (rd_data_stb)           nxt = HS_DATA_SEEN;
                    else if (rd_stat_stb)           nxt = HS_STAT_SEEN;
                end
                HS_DATA_SEEN: begin
                    if (rd_stat_stb) begin
                        pop = 1'b1;
                        nxt = HS_WAIT;
                    end
                end
                HS_STAT_SEEN: begin
                    if (rd_data_stb) begin
                        pop = 1'b1;
                        nxt = HS_WAIT;
                    end
                end
                default: nxt = HS_WAIT;
            endcase
        end
    end

    AST_CLEAN_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (nonempty && !head_err && rd_data_stb) |-> pop);  // R3
    AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_err) |-> (rd_data_stb || rd_stat_stb));  // R4
    AST_ERR_ONE_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nonempty && head_err && st == HS_WAIT && (rd_data_stb ^ rd_stat_stb)) |-> !pop);  // R4

endmodule

// File: rtl/rxerr_fifo.sv
module rxerr_fifo
    import rxerr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_frame,
    input  logic          wr_parity,
    input  logic          wr_break,
    input  logic          rd_data_stb,
    input  logic          rd_stat_stb,
    output logic [DW-1:0] head_data,
    output logic [2:0]    head_stat,
    output logic [CW-1:0] count,
    output logic          overrun,
    output logic          err_irq
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_tag_t in_tag, hd_tag;
    logic    full, empty, pop, push, drop;

    assign in_tag = '{brk: wr_break, par: wr_parity, frm: wr_frame};
    assign push   = wr_en && (!full || pop);
    assign drop   = wr_en && full && !pop;

    rxerr_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .push_tag  (in_tag),
        .pop       (pop),
        .hd_data   (head_data),
        .hd_tag    (hd_tag),
        .occ       (count),
        .full      (full),
        .empty     (empty)
    );

    rxerr_head_fsm u_head (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonempty    (!empty),
        .head_err    (|hd_tag),
        .rd_data_stb (rd_data_stb),
        .rd_stat_stb (rd_stat_stb),
        .pop         (pop)
    );

    assign head_stat = hd_tag;
    assign err_irq   = !empty && (|hd_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (drop)        overrun <= 1'b1;
        else if (rd_stat_stb) overrun <= 1'b0;
    end

    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> (count == FULL_CNT && $stable(head_data)));  // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_stat_stb) |=> overrun);  // R6
    AST_FULL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && pop) |=> (count == FULL_CNT));  // R7
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !err_irq);  // R2

endmodule

// File: tb/rxerr_fifo_tb.sv
`timescale 1ns/1ps
module rxerr_fifo_tb;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_frame = 1'b0, wr_parity = 1'b0, wr_break = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_data_stb = 1'b0, rd_stat_stb = 1'b0;
    logic [7:0] head_data;
    logic [2:0] head_stat;
    logic [4:0] count;
    logic       overrun, err_irq;

    int n_cmp = 0, n_bad = 0;
    logic [10:0] exp_q[$];
    bit m_ovr = 0, seen_d = 0, seen_s = 0;

    always #2.5 clk = ~clk;

    rxerr_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_frame(wr_frame), .wr_parity(wr_parity), .wr_break(wr_break),
        .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
        .head_data(head_data), .head_stat(head_stat), .count(count),
        .overrun(overrun), .err_irq(err_irq)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // monitor: compare all outputs against the scoreboard head
    task automatic compare_all();
        logic [10:0] h;
        h = (exp_q.size() > 0) ? exp_q[0] : 11'h0;
        chk(count == exp_q.size(), "R10 count", count, exp_q.size());
        chk(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
        chk(err_irq == (exp_q.size() > 0 && h[10:8] != 0), "R2 err_irq", err_irq,
            (exp_q.size() > 0 && h[10:8] != 0));
        chk({head_stat, head_data} == h, "R1 head", {head_stat, head_data}, h);
    endtask

    // driver: apply one cycle, update scoreboard from requirements
    task automatic tick(bit w, logic [7:0] d, logic [2:0] s, bit rd, bit rs);
        bit ne, herr, pop, fl;
        wr_en = w; wr_data = d; {wr_break, wr_parity, wr_frame} = s;
        rd_data_stb = rd; rd_stat_stb = rs;
        ne = exp_q.size() > 0;
        herr = ne && exp_q[0][10:8] != 0;
        fl = exp_q.size() == DEPTH;
        pop = 0;
        if (ne) begin
            if (!herr) pop = rd;
            else begin
                seen_d |= rd; seen_s |= rs;
                pop = seen_d && seen_s;
            end
        end
        if (pop) begin
            void'(exp_q.pop_front());
            seen_d = 0; seen_s = 0;
        end
        if (w && (!fl || pop)) exp_q.push_back({s, d});
        if (w && fl && !pop) m_ovr = 1;
        else if (rs) m_ovr = 0;
        @(posedge clk); #1;
        wr_en = 0; rd_data_stb = 0; rd_stat_stb = 0;
        wr_data = '0; {wr_break, wr_parity, wr_frame} = '0;
        compare_all();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(count == 0 && overrun == 0 && err_irq == 0, "R9 reset flags", {count, overrun, err_irq}, 0);
        chk(head_data == 0 && head_stat == 0, "R9 reset head", {head_stat, head_data}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R11: A..E, frame fault on B, parity fault on D
        tick(1, 8'hA1, 3'b000, 0, 0);
        tick(1, 8'hB2, 3'b001, 0, 0);
        chk(err_irq == 0, "R2 tagged write behind clean head", err_irq, 0);
        tick(1, 8'hC3, 3'b000, 0, 0);
        tick(1, 8'hD4, 3'b010, 0, 0);
        tick(1, 8'hE5, 3'b000, 0, 0);
        chk(err_irq == 0, "R11 A at head", err_irq, 0);
        tick(0, 0, 0, 1, 0);
        chk(err_irq == 1 && head_data == 8'hB2, "R11 B at head", {err_irq, head_data}, 9'h1B2);
        tick(0, 0, 0, 1, 0);
        chk(head_data == 8'hB2 && count == 4, "R4 data alone holds head", {head_data, count}, {8'hB2, 5'd4});
        tick(0, 0, 0, 0, 1);
        chk(head_data == 8'hC3 && err_irq == 0, "R4 second read releases", {err_irq, head_data}, 9'h0C3);
        tick(0, 0, 0, 0, 1);
        chk(head_data == 8'hC3, "R3 status read on clean head keeps", head_data, 8'hC3);
        tick(0, 0, 0, 1, 0);
        chk(err_irq == 1 && head_data == 8'hD4, "R11 D at head", {err_irq, head_data}, 9'h1D4);
        tick(0, 0, 0, 0, 1);
        chk(head_data == 8'hD4 && err_irq == 1, "R4 status alone holds head", {err_irq, head_data}, 9'h1D4);
        tick(0, 0, 0, 1, 0);
        chk(head_data == 8'hE5 && err_irq == 0, "R11 E at head", {err_irq, head_data}, 9'h0E5);
        tick(0, 0, 0, 1, 0);
        chk(count == 0, "R3 clean data read pops", count, 0);

        // R8: reads on empty
        tick(0, 0, 0, 1, 1);
        chk(count == 0 && head_data == 0, "R8 reads on empty ignored", count, 0);
        tick(1, 8'h5A, 3'b100, 1, 1);
        chk(count == 1 && head_data == 8'h5A && head_stat == 3'b100, "R8 write with read on empty",
            {count, head_stat, head_data}, {5'd1, 3'b100, 8'h5A});
        tick(0, 0, 0, 1, 1);
        chk(count == 0, "R4 both strobes same cycle", count, 0);

        // R5/R6/R7: fill, overrun
        for (int i = 0; i < DEPTH; i++) tick(1, 8'(8'h10 + i), 3'(i % 3 == 1 ? 3'b010 : 3'b000), 0, 0);
        chk(count == 16, "R10 full count", count, 16);
        tick(1, 8'hEE, 3'b001, 0, 0);
        chk(count == 16 && overrun == 1 && head_data == 8'h10, "R5 drop on full",
            {count, overrun, head_data}, {5'd16, 1'b1, 8'h10});
        tick(0, 0, 0, 0, 0);
        chk(overrun == 1, "R6 overrun sticky", overrun, 1);
        tick(1, 8'hEF, 3'b000, 0, 1);
        chk(overrun == 1 && count == 16, "R6 drop wins over clear", {overrun, count}, {1'b1, 5'd16});
        tick(0, 0, 0, 0, 1);
        chk(overrun == 0, "R6 status read clears", overrun, 0);
        tick(1, 8'h77, 3'b000, 1, 0);
        chk(count == 16 && head_data == 8'h11, "R7 write with read on full", {count, head_data}, {5'd16, 8'h11});
        // drain, errored entries need both reads
        for (int i = 0; i < 40 && exp_q.size() > 0; i++) tick(0, 0, 0, 1, i % 2 == 1);
        chk(count == 0, "R7 drained, last was accepted entry", count, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule